// File: doc/BRIEF.md
# Series-Pack Cell Protection Controller

A synchronous supervisor for a lithium pack of three or four cells in series. It does not measure voltages itself. It receives digital flags from per-cell comparators: above the overcharge level, below the overcharge release level, and below the under-voltage level. It also receives three discharge-current comparator flags of rising severity, a charger-level flag, a load-removed flag and three external control inputs. From these it decides when the charge FET and the discharge FET are switched off. It also decides when the regulator and the monitor amplifier stay enabled and when the monitor-node pull-up is switched on.

Each fault has its own qualification timer. A fault acts only once its flag has been seen on a given number of consecutive clock edges. A single cycle with the flag low restarts that count. The overcurrent-1 delay and the under-voltage delay come from one shared setting, and the under-voltage delay is a fixed multiple of it.

An under-voltage fault passes through a one-cycle discharge-off state into power-down. The pack stays in power-down until a charger is seen and every used cell is back above its under-voltage level. The external control inputs can override the FET outputs in any state.

Top module: `cellguard_ctrl`

## Requirements
- R1: When any used cell's overcharge flag (`cell_ov`) is high on P_OCH_DLY consecutive edges, the block enters overcharge after that edge. In overcharge `chg_fet_off`=1, `dis_fet_off`=0, and `reg_en`, `mon_en` stay 1.
- R2: Overcharge returns to normal at the next edge once every used cell's `cell_rel` flag is 1, or once `oc_lvl1` is 1, provided no higher-priority fault qualifies at that edge.
- R3: When any used cell's `cell_uv` flag is high on P_OC1_DLY*P_OD_RATIO consecutive edges, the block spends one cycle with `dis_fet_off`=1, `chg_fet_off`=0 and `reg_en`=1. It then enters power-down at the following edge.
- R4: In power-down `chg_fet_off`=1, `dis_fet_off`=1, `reg_en`=0, `mon_en`=0 and `pullup_en`=0.
- R5: Power-down is left, to normal, only at an edge where `chg_lvl`=1 and no used cell's `cell_uv` is 1.
- R6: `oc_lvl3`, `oc_lvl2` and `oc_lvl1` qualify after P_OC3_DLY, P_OC2_DLY and P_OC1_DLY consecutive edges respectively. They qualify from normal or from overcharge. The result is `chg_fet_off`=1, `dis_fet_off`=1 and `pullup_en`=1. The block returns to normal at the first edge with `load_gone`=1.
- R7: When faults qualify at the same edge, overcurrent wins over under-voltage, and under-voltage wins over overcharge.
- R8: A fault flag that falls before its delay has elapsed restarts its count, so a flag shorter than its delay changes no output.
- R9: The control inputs override the FET outputs combinationally. `force_off`=1 forces both FETs off. Otherwise, with `sel_float`=0, `sel_lvl`=1 gives charge off and discharge on, and `sel_lvl`=0 gives charge on and discharge off. With `sel_float`=1 and `force_off`=0 the protection state decides.
- R10: Flag bits at positions CELLS and above are ignored.
- R11: After reset the block is in normal: `chg_fet_off`=0, `dis_fet_off`=0, `reg_en`=1, `mon_en`=1 and `pullup_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cell_ov | input | NPOS | Per cell: voltage above overcharge level |
| cell_rel | input | NPOS | Per cell: voltage below overcharge release level |
| cell_uv | input | NPOS | Per cell: voltage below under-voltage level |
| oc_lvl1 | input | 1 | Discharge current above level 1 |
| oc_lvl2 | input | 1 | Discharge current above level 2 |
| oc_lvl3 | input | 1 | Discharge current above level 3 (short) |
| load_gone | input | 1 | Load removed after overcurrent |
| chg_lvl | input | 1 | Monitor node at or above half supply (charger present) |
| force_off | input | 1 | Forces both FETs off |
| sel_float | input | 1 | Selector input is unconnected |
| sel_lvl | input | 1 | Selector level when connected |
| chg_fet_off | output | 1 | Charge FET off |
| dis_fet_off | output | 1 | Discharge FET off |
| reg_en | output | 1 | Regulator enable |
| mon_en | output | 1 | Monitor amplifier enable |
| pullup_en | output | 1 | Monitor-node pull-up enable |

## Verification
A fault flag first presented before edge 1 changes the outputs right after edge D, where D is that fault's delay. Release conditions act one edge after they are presented. The discharge-off state lasts exactly one cycle before power-down. The control overrides act in the same cycle, with no edge in between. The reference model advances once per rising edge and is compared a quarter period later. The directed checks are taken at the falling edge after the counted number of edges, before new stimulus is applied, so each check sees the state that the last edge produced.

// File: rtl/cellguard_pkg.sv
package cellguard_pkg;

   typedef enum logic [2:0] {
      ST_NORM,
      ST_OCHG,
      ST_ODIS,
      ST_PDN,
      ST_OCUR
   } cg_state_e;

   // fault indices; lower index = higher priority
   localparam int FI_OC3 = 0;
   localparam int FI_OC2 = 1;
   localparam int FI_OC1 = 2;
   localparam int FI_UV  = 3;
   localparam int FI_OV  = 4;
   localparam int NFAULT = 5;

   typedef struct packed {
      logic chg_off;
      logic dis_off;
      logic reg_en;
      logic mon_en;
      logic pull_en;
   } cg_out_s;

endpackage

// File: rtl/cg_qual_timer.sv
module cg_qual_timer #(
   parameter int LIM = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   output logic hit
);
   generate
      if (LIM < 2) begin : g_bad
         $error("cg_qual_timer: LIM must be 2 or more");
      end
      else begin : g_count
         localparam int W = $clog2(LIM);
         localparam logic [W-1:0] TOP = W'(LIM - 1);
         logic [W-1:0] cnt;

         // consecutive-edge counter, restarted whenever the flag drops
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!flag)        cnt <= '0;
            else if (cnt != TOP)   cnt <= cnt + 1'b1;
         end

         assign hit = flag && (cnt == TOP);
      end
   endgenerate
endmodule

// File: rtl/cg_cell_reduce.sv
module cg_cell_reduce #(
   parameter int NPOS  = 4,
   parameter int CELLS = 4
) (
   input  logic [NPOS-1:0] ov,
   input  logic [NPOS-1:0] rel,
   input  logic [NPOS-1:0] uv,
   output logic            any_ov,
   output logic            all_rel,
   output logic            any_uv
);
   function automatic logic [NPOS-1:0] used_mask();
      logic [NPOS-1:0] m;
      for (int i = 0; i < NPOS; i++) m[i] = (i < CELLS);
      return m;
   endfunction

   localparam logic [NPOS-1:0] USED = used_mask();

   assign any_ov  = |(ov & USED);
   assign all_rel = &(rel | ~USED);
   assign any_uv  = |(uv & USED);
endmodule

// File: rtl/cg_out_mux.sv
module cg_out_mux
   import cellguard_pkg::*;
(
   input  cg_out_s prot,
   input  logic    force_off,
   input  logic    sel_float,
   input  logic    sel_lvl,
   output cg_out_s fin
);
   always_comb begin
      fin = prot;
      if (force_off) begin
         fin.chg_off = 1'b1;
         fin.dis_off = 1'b1;
      end
      else if (!sel_float) begin
         fin.chg_off = sel_lvl;
         fin.dis_off = !sel_lvl;
      end
   end
endmodule

// File: rtl/cellguard_ctrl.sv
module cellguard_ctrl
   import cellguard_pkg::*;
#(
   parameter int NPOS       = 4,
   parameter int CELLS      = 4,
   parameter int P_OCH_DLY  = 32768,
   parameter int P_OC1_DLY  = 328,
   parameter int P_OC2_DLY  = 82,
   parameter int P_OC3_DLY  = 10,
   parameter int P_OD_RATIO = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPOS-1:0] cell_ov,
   input  logic [NPOS-1:0] cell_rel,
   input  logic [NPOS-1:0] cell_uv,
   input  logic            oc_lvl1,
   input  logic            oc_lvl2,
   input  logic            oc_lvl3,
   input  logic            load_gone,
   input  logic            chg_lvl,
   input  logic            force_off,
   input  logic            sel_float,
   input  logic            sel_lvl,
   output logic            chg_fet_off,
   output logic            dis_fet_off,
   output logic            reg_en,
   output logic            mon_en,
   output logic            pullup_en
);
   localparam int OD_DLY = P_OC1_DLY * P_OD_RATIO;

   generate
      if (CELLS < 3 || CELLS > 4 || CELLS > NPOS) begin : g_cells_bad
         $error("cellguard_ctrl: CELLS must be 3 or 4 and fit in NPOS");
      end
      if (P_OD_RATIO < 1) begin : g_ratio_bad
         $error("cellguard_ctrl: P_OD_RATIO must be positive");
      end
   endgenerate

   function automatic int lim_of(input int k);
      case (k)
         FI_OC3:  return P_OC3_DLY;
         FI_OC2:  return P_OC2_DLY;
         FI_OC1:  return P_OC1_DLY;
         FI_UV:   return OD_DLY;
         default: return P_OCH_DLY;
      endcase
   endfunction

   logic any_ov, all_rel, any_uv;

   cg_cell_reduce #(.NPOS(NPOS), .CELLS(CELLS)) u_reduce (
      .ov      (cell_ov),
      .rel     (cell_rel),
      .uv      (cell_uv),
      .any_ov  (any_ov),
      .all_rel (all_rel),
      .any_uv  (any_uv)
   );

   logic [NFAULT-1:0] raw, qual;

   assign raw[FI_OC3] = oc_lvl3;
   assign raw[FI_OC2] = oc_lvl2;
   assign raw[FI_OC1] = oc_lvl1;
   assign raw[FI_UV]  = any_uv;
   assign raw[FI_OV]  = any_ov;

   genvar k;
   generate
      for (k = 0; k < NFAULT; k++) begin : g_tmr
         cg_qual_timer #(.LIM(lim_of(k))) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .flag  (raw[k]),
            .hit   (qual[k])
         );
      end
   endgenerate

   logic oc_q;
   assign oc_q = qual[FI_OC3] | qual[FI_OC2] | qual[FI_OC1];

   cg_state_e st, nxt;

   always_comb begin
      nxt = st;
      case (st)
         ST_NORM: begin
            if (oc_q)              nxt = ST_OCUR;
            else if (qual[FI_UV])  nxt = ST_ODIS;
            else if (qual[FI_OV])  nxt = ST_OCHG;
         end
         ST_OCHG: begin
            if (oc_q)                     nxt = ST_OCUR;
            else if (qual[FI_UV])         nxt = ST_ODIS;
            else if (oc_lvl1 || all_rel)  nxt = ST_NORM;
         end
         ST_ODIS:  nxt = ST_PDN;
         ST_PDN:   if (chg_lvl && !any_uv) nxt = ST_NORM;
         ST_OCUR:  if (load_gone)          nxt = ST_NORM;
         default:  nxt = ST_NORM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_NORM;
      else        st <= nxt;
   end

   cg_out_s prot, fin;

   always_comb begin
      prot = '{chg_off: 1'b0, dis_off: 1'b0, reg_en: 1'b1, mon_en: 1'b1, pull_en: 1'b0};
      case (st)
         ST_OCHG: prot.chg_off = 1'b1;
         ST_ODIS: prot.dis_off = 1'b1;
         ST_PDN:  prot = '{chg_off: 1'b1, dis_off: 1'b1, reg_en: 1'b0, mon_en: 1'b0, pull_en: 1'b0};
         ST_OCUR: begin
            prot.chg_off = 1'b1;
            prot.dis_off = 1'b1;
            prot.pull_en = 1'b1;
         end
         default: ;
      endcase
   end

   cg_out_mux u_mux (
      .prot      (prot),
      .force_off (force_off),
      .sel_float (sel_float),
      .sel_lvl   (sel_lvl),
      .fin       (fin)
   );

   assign chg_fet_off = fin.chg_off;
   assign dis_fet_off = fin.dis_off;
   assign reg_en      = fin.reg_en;
   assign mon_en      = fin.mon_en;
   assign pullup_en   = fin.pull_en;
endmodule

// File: rtl/cellguard_chk.sv
module cellguard_chk (
   input logic clk,
   input logic rst_n,
   input logic oc_lvl1,
   input logic oc_lvl2,
   input logic oc_lvl3,
   input logic chg_lvl,
   input logic force_off,
   input logic sel_float,
   input logic chg_fet_off,
   input logic dis_fet_off,
   input logic reg_en,
   input logic mon_en,
   input logic pullup_en
);
   // R9: hard off wins over everything
   a_r9_force_both_off: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |-> (chg_fet_off && dis_fet_off));

   // R4: power-down outputs when no override is active
   a_r4_pdn_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_en && !force_off && sel_float) |-> (chg_fet_off && dis_fet_off && !mon_en && !pullup_en));

   // R5: waking up needs the charger flag at the deciding edge
   a_r5_wake_needs_charger: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_en) |-> $past(chg_lvl));

   // R6: pull-up only follows a current fault flag
   a_r6_pullup_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pullup_en) |-> $past(oc_lvl1 || oc_lvl2 || oc_lvl3));

   // R3: power-down is preceded by the discharge-off cycle
   a_r3_pdn_after_dis_off: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_en) |-> ($past(dis_fet_off) || !$past(sel_float) || $past(force_off)));
endmodule

bind cellguard_ctrl cellguard_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .oc_lvl1     (oc_lvl1),
   .oc_lvl2     (oc_lvl2),
   .oc_lvl3     (oc_lvl3),
   .chg_lvl     (chg_lvl),
   .force_off   (force_off),
   .sel_float   (sel_float),
   .chg_fet_off (chg_fet_off),
   .dis_fet_off (dis_fet_off),
   .reg_en      (reg_en),
   .mon_en      (mon_en),
   .pullup_en   (pullup_en)
);

// File: tb/sim_cellguard_ctrl.sv
module sim_cellguard_ctrl;
   localparam int CLK_P = 10;
   localparam int NC    = 3;
   localparam int D_OCH = 20;
   localparam int D_OC1 = 4;
   localparam int D_OC2 = 6;
   localparam int D_OC3 = 2;
   localparam int RATIO = 10;

   logic clk = 0, rst_n = 0;
   logic [3:0] ov = 0, rel = 4'hF, uv = 0;
   logic oc1 = 0, oc2 = 0, oc3 = 0, load_gone = 0, chg_lvl = 0;
   logic force_off = 0, sel_float = 1, sel_lvl = 0;
   logic chg_fet_off, dis_fet_off, reg_en, mon_en, pullup_en;

   int checks = 0, errors = 0;

   always #(CLK_P/2) clk = ~clk;

   cellguard_ctrl #(.NPOS(4), .CELLS(NC), .P_OCH_DLY(D_OCH), .P_OC1_DLY(D_OC1),
                    .P_OC2_DLY(D_OC2), .P_OC3_DLY(D_OC3), .P_OD_RATIO(RATIO)) u0 (
      .clk(clk), .rst_n(rst_n), .cell_ov(ov), .cell_rel(rel), .cell_uv(uv),
      .oc_lvl1(oc1), .oc_lvl2(oc2), .oc_lvl3(oc3), .load_gone(load_gone),
      .chg_lvl(chg_lvl), .force_off(force_off), .sel_float(sel_float), .sel_lvl(sel_lvl),
      .chg_fet_off(chg_fet_off), .dis_fet_off(dis_fet_off), .reg_en(reg_en),
      .mon_en(mon_en), .pullup_en(pullup_en));

   // outputs packed as {chg_off, dis_off, reg_en, mon_en, pullup}
   function automatic logic [4:0] act();
      return {chg_fet_off, dis_fet_off, reg_en, mon_en, pullup_en};
   endfunction

   task automatic check(input string tag, input logic [4:0] a, input logic [4:0] e);
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s: outputs %b expected %b at %0t", tag, a, e, $time);
      end
   endtask

   // behavioural reference: 0 normal, 1 overcharge, 2 dis-off, 3 power-down, 4 overcurrent
   int mst = 0;
   int run[5];
   int dly[5] = '{D_OC3, D_OC2, D_OC1, D_OC1*RATIO, D_OCH};

   function automatic logic [4:0] model_out();
      logic [4:0] o;
      case (mst)
         1: o = 5'b10110;
         2: o = 5'b01110;
         3: o = 5'b11000;
         4: o = 5'b11111;
         default: o = 5'b00110;
      endcase
      if (force_off) o[4:3] = 2'b11;
      else if (!sel_float) o[4:3] = {sel_lvl, !sel_lvl};
      return o;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mst = 0;
         for (int i = 0; i < 5; i++) run[i] = 0;
      end
      else begin
         bit a_ov, a_uv, a_rel;
         bit f[5];
         bit q[5];
         a_ov = 0; a_uv = 0; a_rel = 1;
         for (int i = 0; i < NC; i++) begin
            a_ov |= ov[i]; a_uv |= uv[i]; a_rel &= rel[i];
         end
         f = '{oc3, oc2, oc1, a_uv, a_ov};
         for (int i = 0; i < 5; i++) begin
            run[i] = f[i] ? run[i] + 1 : 0;
            q[i] = (run[i] >= dly[i]);
         end
         case (mst)
            0: if (q[0] || q[1] || q[2]) mst = 4; else if (q[3]) mst = 2; else if (q[4]) mst = 1;
            1: if (q[0] || q[1] || q[2]) mst = 4; else if (q[3]) mst = 2; else if (oc1 || a_rel) mst = 0;
            2: mst = 3;
            3: if (chg_lvl && !a_uv) mst = 0;
            default: if (load_gone) mst = 0;
         endcase
      end
      #(CLK_P/4);
      if (rst_n) begin
         string t;
         if (force_off || !sel_float) t = "R9";
         else case (mst)
            1: t = "R1"; 2: t = "R3"; 3: t = "R4"; 4: t = "R6"; default: t = "R2";
         endcase
         check({t, " per-cycle"}, act(), model_out());
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_P*200000);
      errors++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      check("R11 reset state", act(), 5'b00110);

      // R8: 19-cycle glitch on cell 1 overcharge flag
      ov[1] = 1; rel[1] = 0; tick(D_OCH-1);
      ov[1] = 0; tick(1);
      check("R8 short flag ignored", act(), 5'b00110);
      ov[1] = 1; tick(D_OCH-1);
      check("R1 before delay", act(), 5'b00110);
      tick(1);
      check("R1 overcharge entered", act(), 5'b10110);

      // R2: release by all cells below release level
      ov[1] = 0; tick(2);
      check("R2 held while one cell above release", act(), 5'b10110);
      rel[1] = 1; tick(1);
      check("R2 release by voltage", act(), 5'b00110);

      // R2: release by load current
      ov[0] = 1; rel[0] = 0; tick(D_OCH);
      check("R1 overcharge re-entered", act(), 5'b10110);
      ov[0] = 0; oc1 = 1; tick(1);
      oc1 = 0;
      check("R2 release by load", act(), 5'b00110);
      tick(1);

      // R10: unused position 3 flags have no effect
      ov[3] = 1; uv[3] = 1; rel[3] = 0; oc1 = 0; tick(D_OC1*RATIO + 5);
      check("R10 unused cell ignored", act(), 5'b00110);
      ov[3] = 0; uv[3] = 0; rel = 4'hF; tick(1);

      // R6: three overcurrent levels
      oc3 = 1; tick(D_OC3-1);
      check("R6 level3 before delay", act(), 5'b00110);
      tick(1);
      check("R6 level3 trip", act(), 5'b11111);
      oc3 = 0; tick(2);
      check("R6 latched until load removed", act(), 5'b11111);
      load_gone = 1; tick(1); load_gone = 0;
      check("R6 release", act(), 5'b00110);
      oc2 = 1; tick(D_OC2-1);
      check("R6 level2 before delay", act(), 5'b00110);
      tick(1);
      check("R6 level2 trip", act(), 5'b11111);
      oc2 = 0; load_gone = 1; tick(1); load_gone = 0;
      oc1 = 1; tick(D_OC1-1);
      check("R6 level1 before delay", act(), 5'b00110);
      tick(1);
      check("R6 level1 trip", act(), 5'b11111);
      oc1 = 0; load_gone = 1; tick(1); load_gone = 0;

      // R7: under-voltage, overcharge and overcurrent qualify on one edge
      uv[2] = 1; tick(D_OC1*RATIO - D_OCH);
      ov[0] = 1; rel[0] = 0; tick(D_OCH - D_OC1);
      oc1 = 1; tick(D_OC1);
      check("R7 overcurrent wins", act(), 5'b11111);
      oc1 = 0; ov[0] = 0; rel = 4'hF; load_gone = 1; tick(1); load_gone = 0;
      check("R6 released to normal", act(), 5'b00110);
      tick(1);
      check("R3 discharge off cycle", act(), 5'b01110);
      tick(1);
      check("R4 power-down", act(), 5'b11000);

      // R5: exit rules
      chg_lvl = 1; tick(2);
      check("R5 charger but cell low", act(), 5'b11000);
      chg_lvl = 0; uv[2] = 0; tick(2);
      check("R5 cells ok but no charger", act(), 5'b11000);
      chg_lvl = 1; tick(1); chg_lvl = 0;
      check("R5 wake to normal", act(), 5'b00110);

      // R7: under-voltage against overcharge on the same edge
      uv[1] = 1; tick(D_OC1*RATIO - D_OCH);
      ov[2] = 1; rel[2] = 0; tick(D_OCH - 1);
      check("R3 before delay", act(), 5'b00110);
      tick(1);
      check("R7 under-voltage wins over overcharge", act(), 5'b01110);
      ov[2] = 0; rel = 4'hF; uv[1] = 0; tick(1);
      check("R4 power-down again", act(), 5'b11000);
      chg_lvl = 1; tick(1); chg_lvl = 0;

      // R9: control overrides, same cycle
      force_off = 1; #1;
      check("R9 force off", act(), 5'b11110);
      force_off = 0; sel_float = 0; sel_lvl = 1; #1;
      check("R9 charge disabled only", act(), 5'b10110);
      sel_lvl = 0; #1;
      check("R9 discharge disabled only", act(), 5'b01110);
      sel_float = 1; #1;
      check("R9 protection decides", act(), 5'b00110);
      tick(3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule